// File: doc/BRIEF.md
# Hub Low-Speed Port Gating Controller

This block sits in the downstream path of a hub repeater and decides, port by port, whether traffic from the upstream side may be repeated out. It runs on a clock at the full-speed bit rate. It watches four decoded events from the upstream receiver: start-of-packet detection, a strobe for a valid packet identifier, the identifier byte, and end of packet. Each port has a speed flag, which is an input. Ports flagged as low-speed stay shut while ordinary full-speed packets pass.

When the first identifier of a packet is the preamble code, the block enters a short setup window. During this window every port is driven idle and none repeats. The window is no longer than four bit times. After it, every port, including the low-speed ones, is opened to carry the low-speed packet that follows. The end of that packet closes the low-speed ports again.

The length of the setup window is a parameter of 1 to 4 clock cycles. Line-state decoding, speed detection at attach and the low-speed repeater itself belong to other blocks.

Top module: `hub_ls_gate`

## Requirements
- R1: After reset, each port's repeat enable equals the inverse of its low-speed flag, and every drive-idle output is 0.
- R2: While a full-speed packet is in progress, a port flagged as low-speed has its repeat enable at 0.
- R3: The preamble code is byte 0x3C, and only that byte is recognized as a preamble. Its low nibble 4'b1100 is the type, and its high nibble must be the bitwise complement of the low nibble. Every other byte, including 0x3C with a corrupted high nibble, is treated as an ordinary full-speed packet.
- R4: Only the first identifier after a start-of-packet is examined. A preamble code arriving later in the same packet has no effect on the outputs.
- R5: For SETUP_CYC cycles, starting at the clock edge that samples the preamble identifier strobe, all repeat enables are 0 and all drive-idle outputs are 1.
- R6: At edge SETUP_CYC+1 after the preamble identifier strobe, every port's repeat enable becomes 1 and its drive-idle output becomes 0. With the default SETUP_CYC of 3, this is within four bit times.
- R7: While the low-speed window is open, start-of-packet and identifier strobes are ignored. An end-of-packet closes the window at the next edge, and the outputs return to the R1 pattern.
- R8: An end-of-packet strobe that arrives during the setup window is ignored, and the window still opens on time.
- R9: An end-of-packet strobe during a full-speed packet returns the block to idle. Full-speed ports keep repeating and low-speed ports stay shut.
- R10: The gating applies independently to each port according to that port's own speed flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-speed bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sync_det | input | 1 | Start of an upstream packet detected |
| pid_vld | input | 1 | Identifier byte on `pid` is valid this cycle |
| pid | input | 8 | Decoded packet identifier byte |
| eop | input | 1 | End of the current upstream packet |
| port_ls | input | N_PORTS | Per-port low-speed flag, fixed at attach |
| rpt_en | output | N_PORTS | Per-port repeat enable |
| drv_idle | output | N_PORTS | Per-port force-idle during the setup window |

## Verification
The assertions assume that the event strobes are single-cycle pulses in protocol order. A start-of-packet comes first, followed by exactly one identifier strobe before any end-of-packet. Speed flags are assumed to stay stable within a packet. The stimulus follows these assumptions: for every speed-flag mask over four ports, it sends one packet for each of the 256 identifier bytes. Each packet is framed by single pulses. The speed flags change only between packets. Stray strobes are sent only into states where the requirements say they must be ignored.

// File: rtl/hub_ls_pkg.sv
package hub_ls_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HDR    = 3'd1,
    ST_FSBODY = 3'd2,
    ST_SETUP  = 3'd3,
    ST_LSWIN  = 3'd4
  } gate_st_e;

  localparam logic [3:0] PRE_TYPE = 4'b1100;

  // Type nibble must match and the check nibble must be its complement.
  function automatic logic pid_is_pre(input logic [7:0] p);
    return (p[3:0] == PRE_TYPE) && (p[7:4] == ~p[3:0]);
  endfunction

endpackage

// File: rtl/lsg_pid_match.sv
module lsg_pid_match
  import hub_ls_pkg::*;
(
  input  logic       pid_vld,
  input  logic [7:0] pid,
  output logic       pre_hit
);

  always_comb begin
    pre_hit = pid_vld && pid_is_pre(pid);
  end

endmodule

// File: rtl/lsg_seq.sv
module lsg_seq
  import hub_ls_pkg::*;
#(
  parameter int SETUP_CYC = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sync_det,
  input  logic     pid_vld,
  input  logic     pre_hit,
  input  logic     eop,
  output gate_st_e st
);

  localparam int CW = 2;
  localparam logic [CW-1:0] CNT_LAST = CW'(SETUP_CYC - 1);

  gate_st_e        st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    case (st_q)
      ST_IDLE:   if (sync_det) st_d = ST_HDR;
      ST_HDR: begin
        if (eop)          st_d = ST_IDLE;
        else if (pre_hit) begin
          st_d   = ST_SETUP;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
        else if (pid_vld) st_d = ST_FSBODY;
      end
      ST_FSBODY: if (eop) st_d = ST_IDLE;
      ST_SETUP: begin
        cnt_en = 1'b1;
        if (cnt_q == CNT_LAST) begin
          st_d  = ST_LSWIN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_LSWIN:  if (eop) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign st = st_q;

endmodule

// File: rtl/lsg_port_gate.sv
module lsg_port_gate
  import hub_ls_pkg::*;
#(
  parameter int N = 4
) (
  input  gate_st_e       st,
  input  logic [N-1:0]   port_ls,
  output logic [N-1:0]   rpt_en,
  output logic [N-1:0]   drv_idle
);

  for (genvar i = 0; i < N; i++) begin : g_port
    always_comb begin
      case (st)
        ST_SETUP: begin
          rpt_en[i]   = 1'b0;
          drv_idle[i] = 1'b1;
        end
        ST_LSWIN: begin
          rpt_en[i]   = 1'b1;
          drv_idle[i] = 1'b0;
        end
        default: begin
          rpt_en[i]   = ~port_ls[i];
          drv_idle[i] = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/hub_ls_gate.sv
module hub_ls_gate
  import hub_ls_pkg::*;
#(
  parameter int N_PORTS   = 4,
  parameter int SETUP_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_det,
  input  logic               pid_vld,
  input  logic [7:0]         pid,
  input  logic               eop,
  input  logic [N_PORTS-1:0] port_ls,
  output logic [N_PORTS-1:0] rpt_en,
  output logic [N_PORTS-1:0] drv_idle
);

  logic [1:0] rst_q;
  logic       rst_sync;
  logic       pre_hit;
  gate_st_e   st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync = rst_q[1];

  lsg_pid_match u_match (
    .pid_vld (pid_vld),
    .pid     (pid),
    .pre_hit (pre_hit)
  );

  lsg_seq #(.SETUP_CYC(SETUP_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync),
    .sync_det (sync_det),
    .pid_vld  (pid_vld),
    .pre_hit  (pre_hit),
    .eop      (eop),
    .st       (st)
  );

  lsg_port_gate #(.N(N_PORTS)) u_gate (
    .st       (st),
    .port_ls  (port_ls),
    .rpt_en   (rpt_en),
    .drv_idle (drv_idle)
  );

endmodule

// File: rtl/hub_ls_gate_chk.sv
module hub_ls_gate_chk
  import hub_ls_pkg::*;
#(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pid_vld,
  input logic         pre_hit,
  input logic         eop,
  input gate_st_e     st,
  input logic [N-1:0] port_ls,
  input logic [N-1:0] rpt_en,
  input logic [N-1:0] drv_idle
);

  logic [2:0] setup_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 setup_len <= 3'd0;
    else if (st == ST_SETUP)    setup_len <= (setup_len == 3'd7) ? 3'd7 : setup_len + 3'd1;
    else                        setup_len <= 3'd0;
  end

  // R2
  ls_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_LSWIN) |-> ((rpt_en & port_ls) == '0));

  // R3
  pre_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR && pid_vld && pre_hit && !eop) |=> (st == ST_SETUP));

  // R5
  setup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SETUP) |-> (rpt_en == '0 && drv_idle == '1));

  // R6
  setup_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SETUP) |-> (setup_len < 3'd4));

  // R6
  setup_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_SETUP && st != ST_SETUP) |-> (st == ST_LSWIN && rpt_en == '1));

  // R7
  win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LSWIN && eop) |=> ((rpt_en & port_ls) == '0));

endmodule

bind hub_ls_gate hub_ls_gate_chk #(.N(N_PORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync),
  .pid_vld  (pid_vld),
  .pre_hit  (pre_hit),
  .eop      (eop),
  .st       (st),
  .port_ls  (port_ls),
  .rpt_en   (rpt_en),
  .drv_idle (drv_idle)
);

// File: tb/hub_ls_gate_tb.sv
module hub_ls_gate_tb;

  localparam int CLK_P = 10;
  localparam int NP    = 4;
  localparam int SC    = 3;
  localparam logic [NP-1:0] ALL = '1;

  logic          clk;
  logic          rst_n;
  logic          sync_det;
  logic          pid_vld;
  logic [7:0]    pid;
  logic          eop;
  logic [NP-1:0] port_ls;
  logic [NP-1:0] rpt_en;
  logic [NP-1:0] drv_idle;

  int n_chk;
  int n_err;
  bit done;

  hub_ls_gate #(.N_PORTS(NP), .SETUP_CYC(SC)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_det (sync_det),
    .pid_vld  (pid_vld),
    .pid      (pid),
    .eop      (eop),
    .port_ls  (port_ls),
    .rpt_en   (rpt_en),
    .drv_idle (drv_idle)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [NP-1:0] exp_rpt,
                     input logic [NP-1:0] exp_idle);
    n_chk++;
    if (rpt_en !== exp_rpt || drv_idle !== exp_idle) begin
      n_err++;
      $display("FAIL %s: rpt_en=%b drv_idle=%b expected rpt_en=%b drv_idle=%b (ls=%b pid=%h)",
               req, rpt_en, drv_idle, exp_rpt, exp_idle, port_ls, pid);
    end
  endtask

  function automatic bit is_pre(input logic [7:0] p);
    return p == 8'h3C;
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 0;
    rst_n = 1'b0; sync_det = 1'b0; pid_vld = 1'b0; pid = 8'h00; eop = 1'b0;
    port_ls = 4'b0101;
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
    chk("R1 reset state", ~port_ls, '0);

    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 256; p++) begin
        port_ls = NP'(m);
        sync_det = 1'b1; step(); sync_det = 1'b0;
        chk("R2 header of packet", ~port_ls, '0);
        pid_vld = 1'b1; pid = 8'(p); step(); pid_vld = 1'b0;
        if (is_pre(8'(p))) begin
          for (int k = 0; k < SC; k++) begin
            chk("R5 setup idle", '0, ALL);
            if (k == 0) eop = 1'b1;   // R8 stray end-of-packet in setup
            step();
            eop = 1'b0;
          end
          chk("R6 R8 window open", ALL, '0);
          sync_det = 1'b1; pid_vld = 1'b1; pid = 8'h2D; step();
          sync_det = 1'b0; pid_vld = 1'b0;
          chk("R7 strobes ignored in window", ALL, '0);
          eop = 1'b1; step(); eop = 1'b0;
          chk("R7 R10 window closed", ~port_ls, '0);
        end else begin
          chk("R3 R10 non-preamble is full-speed", ~port_ls, '0);
          pid_vld = 1'b1; pid = 8'h3C; step(); pid_vld = 1'b0;
          chk("R4 later preamble ignored", ~port_ls, '0);
          eop = 1'b1; step(); eop = 1'b0;
          chk("R9 back to idle", ~port_ls, '0);
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule